// File: doc/BRIEF.md
# Burst-Correcting ECC Simple Dual-Port RAM

This block is a RAM with one write port and one read port that keeps each 32-bit data word together with 8 check bits in a 40-bit stored codeword. On every write the check bits are computed from the data and stored alongside it. On every read the stored codeword is checked again. Any error confined to one bit, to two neighbouring bits or to three consecutive bits of the 40-bit codeword is repaired before the word leaves the block. Each read also returns two flags that report what was found.

The check matrix is built when the design is elaborated. The check bits have identity columns. The 32 data columns are then chosen one after another so that each new error pattern of length one, two or three gets a nonzero syndrome that no other such pattern uses. The read path compares the syndrome against all 117 pattern syndromes at once. A parameter can add a register in front of the decoder, which trades one cycle of read latency for a shorter path from the RAM output to the data pins.

A 40-bit test mask on the write port is XORed into the codeword before it is stored. A bench uses it to plant any error pattern it wants. Byte enables, unequal port widths and defined behaviour for a read and a write to the same address in the same cycle are not provided.

Top module: `adj_ecc_ram`

## Requirements
- R1: A word written with an all-zero flip mask reads back unchanged with rd_err=0 and rd_uerr=0.
- R2: A read sampled with rd_en=1 on a clock edge raises rd_valid for exactly one cycle, with data and flags valid in that cycle. This happens one edge later when PIPE=0 and two edges later when PIPE=1. rd_valid stays 0 at all other times.
- R3: Codeword layout: bits [7:0] hold the check bits and data bit i is stored at codeword bit i+8. A flip of any single one of the 40 bits is corrected, giving rd_err=1, rd_uerr=0 and the written data.
- R4: Any two flipped bits at neighbouring codeword positions are corrected, giving rd_err=1, rd_uerr=0 and the written data.
- R5: Any three flipped bits at consecutive codeword positions are corrected, giving rd_err=1, rd_uerr=0 and the written data.
- R6: Two flipped data bits at non-neighbouring positions are never silently accepted. rd_err is 1, and either rd_uerr is 1 or the returned data differs from the written data.
- R7: The flag encoding is {rd_err,rd_uerr}: 00 for a clean read, 10 for a corrected read and 11 for an uncorrectable read. On an uncorrectable read, rd_data is the stored data field without correction. rd_uerr=1 never appears with rd_err=0.
- R8: After reset, with no read in progress, rd_valid, rd_err and rd_uerr are 0 and rd_data is 0.
- R9: The flip mask affects only the codeword written in that cycle. Rewriting an address with a zero mask replaces an earlier corrupted codeword, and the next read is clean.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Data word to store |
| wr_flip | input | DW+CBITS | Test mask XORed into the stored codeword |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | AW | Read address |
| rd_valid | output | 1 | Read result valid this cycle |
| rd_data | output | DW | Corrected (or raw, if uncorrectable) data |
| rd_err | output | 1 | Nonzero syndrome seen |
| rd_uerr | output | 1 | Syndrome matched no correctable pattern |

## Verification
The bench plants every one of the 117 correctable bursts, including those at the two ends of the codeword and those that straddle the boundary between check bits and data. A matrix whose greedy search reused a syndrome would miscorrect one of them, and a matcher off by one position would return damaged data. Random non-adjacent data doubles and wider random masks probe aliasing. A decoder that ignored a nonzero syndrome would hand back wrong data with clean flags, and one that applied a partial fix on a miss would break the raw pass-through promised for rd_uerr. Both latency options run side by side, so a misplaced pipeline register would show up as rd_valid in the wrong cycle. A rewrite of a corrupted address catches a mask that lingers in the stored word.

// File: rtl/adj_ecc_ram.sv
module adj_ecc_ram #(
  parameter int DW    = 32,
  parameter int CBITS = 8,
  parameter int AW    = 8,
  parameter bit PIPE  = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [AW-1:0]         wr_addr,
  input  logic [DW-1:0]         wr_data,
  input  logic [DW+CBITS-1:0]   wr_flip,
  input  logic                  rd_en,
  input  logic [AW-1:0]         rd_addr,
  output logic                  rd_valid,
  output logic [DW-1:0]         rd_data,
  output logic                  rd_err,
  output logic                  rd_uerr
);
  localparam int NCW   = DW + CBITS;
  localparam int DEPTH = 1 << AW;
  localparam int NSYN  = 1 << CBITS;
  localparam int NPAT  = 3 * NCW;

  function automatic logic [NCW*CBITS-1:0] build_cols();
    logic [NCW*CBITS-1:0] c;
    logic [NSYN-1:0]      used;
    logic [CBITS-1:0]     a, b, cand, s2, s3;
    logic                 found;
    c    = '0;
    used = '0;
    for (int p = 0; p < CBITS; p++) begin
      c[p*CBITS +: CBITS] = CBITS'(1) << p;
      used[c[p*CBITS +: CBITS]] = 1'b1;
      if (p >= 1) used[c[p*CBITS +: CBITS] ^ c[(p-1)*CBITS +: CBITS]] = 1'b1;
      if (p >= 2) used[c[p*CBITS +: CBITS] ^ c[(p-1)*CBITS +: CBITS] ^ c[(p-2)*CBITS +: CBITS]] = 1'b1;
    end
    for (int j = CBITS; j < NCW; j++) begin
      a     = c[(j-1)*CBITS +: CBITS];
      b     = c[(j-2)*CBITS +: CBITS];
      found = 1'b0;
      for (int v = 1; v < NSYN; v++) begin
        if (!found) begin
          cand = CBITS'(v);
          s2   = cand ^ a;
          s3   = s2 ^ b;
          if (!used[cand] && !used[s2] && !used[s3] &&
              s2 != '0 && s3 != '0 && s3 != cand) begin
            found = 1'b1;
            c[j*CBITS +: CBITS] = cand;
            used[cand] = 1'b1;
            used[s2]   = 1'b1;
            used[s3]   = 1'b1;
          end
        end
      end
    end
    return c;
  endfunction

  localparam logic [NCW*CBITS-1:0] COLS = build_cols();

  function automatic logic [CBITS-1:0] pat_syn(int p, int len);
    logic [CBITS-1:0] s;
    s = '0;
    for (int k = 0; k < len; k++) s ^= COLS[(p+k)*CBITS +: CBITS];
    return s;
  endfunction

  function automatic logic [NCW-1:0] pat_mask(int p, int len);
    logic [NCW-1:0] m;
    m = '0;
    for (int k = 0; k < len; k++) m[p+k] = 1'b1;
    return m;
  endfunction

  logic [NCW-1:0]   mem [DEPTH];
  logic [CBITS-1:0] wr_chk;
  logic [NCW-1:0]   mem_q;
  logic             v_q;
  logic [NCW-1:0]   dec_cw;
  logic             dec_v;
  logic [CBITS-1:0] syn;
  logic [NPAT-1:0]  hitv;
  logic [NCW-1:0]   contrib [NPAT];
  logic [NCW-1:0]   fix;

  always_comb begin
    wr_chk = '0;
    for (int i = 0; i < DW; i++)
      if (wr_data[i]) wr_chk ^= COLS[(i+CBITS)*CBITS +: CBITS];
  end

  always_ff @(posedge clk)
    if (wr_en) mem[wr_addr] <= {wr_data, wr_chk} ^ wr_flip;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_q <= '0;
      v_q   <= 1'b0;
    end else begin
      v_q <= rd_en;
      if (rd_en) mem_q <= mem[rd_addr];
    end
  end

  generate
    if (PIPE) begin : g_pipe
      logic [NCW-1:0] cw_p;
      logic           v_p;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          cw_p <= '0;
          v_p  <= 1'b0;
        end else begin
          cw_p <= mem_q;
          v_p  <= v_q;
        end
      end
      assign dec_cw = cw_p;
      assign dec_v  = v_p;
    end else begin : g_flat
      assign dec_cw = mem_q;
      assign dec_v  = v_q;
    end
  endgenerate

  always_comb begin
    syn = '0;
    for (int i = 0; i < NCW; i++)
      if (dec_cw[i]) syn ^= COLS[i*CBITS +: CBITS];
  end

  generate
    for (genvar p = 0; p < NCW; p++) begin : g_pos
      for (genvar l = 1; l <= 3; l++) begin : g_len
        if (p + l <= NCW) begin : g_on
          localparam logic [CBITS-1:0] PSYN = pat_syn(p, l);
          assign hitv[p*3+l-1]    = (syn == PSYN);
          assign contrib[p*3+l-1] = hitv[p*3+l-1] ? pat_mask(p, l) : '0;
        end else begin : g_off
          assign hitv[p*3+l-1]    = 1'b0;
          assign contrib[p*3+l-1] = '0;
        end
      end
    end
  endgenerate

  always_comb begin
    fix = '0;
    for (int i = 0; i < NPAT; i++) fix |= contrib[i];
  end

  logic [NCW-1:0] fixed_cw;
  assign fixed_cw = dec_cw ^ fix;

  assign rd_valid = dec_v;
  assign rd_err   = |syn;
  assign rd_uerr  = (|syn) & ~(|hitv);
  assign rd_data  = fixed_cw[NCW-1:CBITS];

endmodule

// File: rtl/adj_ecc_ram_chk.sv
module adj_ecc_ram_chk #(
  parameter int DW   = 32,
  parameter int NCW  = 40,
  parameter bit PIPE = 1'b0
) (
  input logic           clk,
  input logic           rst_n,
  input logic           rd_en,
  input logic           rd_valid,
  input logic           rd_err,
  input logic           rd_uerr,
  input logic [DW-1:0]  rd_data,
  input logic [NCW-1:0] dec_cw
);
  logic q1, q2;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q1 <= 1'b0;
      q2 <= 1'b0;
    end else begin
      q1 <= rd_en;
      q2 <= q1;
    end
  end

  a_r2_valid_timing: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid == (PIPE ? q2 : q1));

  a_r7_uerr_needs_err: assert property (@(posedge clk) disable iff (!rst_n)
    rd_uerr |-> rd_err);

  a_r1_clean_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_err |-> rd_data == dec_cw[NCW-1:NCW-DW]);

  a_r7_uncorr_raw: assert property (@(posedge clk) disable iff (!rst_n)
    rd_uerr |-> rd_data == dec_cw[NCW-1:NCW-DW]);
endmodule

bind adj_ecc_ram adj_ecc_ram_chk #(.DW(DW), .NCW(NCW), .PIPE(PIPE)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_valid(rd_valid),
  .rd_err(rd_err), .rd_uerr(rd_uerr), .rd_data(rd_data), .dec_cw(dec_cw)
);

// File: tb/test_adj_ecc_ram.sv
module test_adj_ecc_ram;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [39:0] wr_flip = '0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_addr = '0;
  logic        v0, v1, e0, e1, u0, u1;
  logic [31:0] d0, d1;
  int checks = 0;
  int failures = 0;
  int ue_seen = 0;
  bit done = 0;

  logic [31:0] c_d0, c_d1;
  logic        c_e0, c_e1, c_u0, c_u1;

  always #10 clk = ~clk;

  adj_ecc_ram #(.PIPE(1'b0)) i_adj_ecc_ram (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_flip(wr_flip), .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(v0),
    .rd_data(d0), .rd_err(e0), .rd_uerr(u0));

  adj_ecc_ram #(.PIPE(1'b1)) i_adj_ecc_ram_pipe (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_flip(wr_flip), .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(v1),
    .rd_data(d1), .rd_err(e1), .rd_uerr(u1));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int popc(input logic [39:0] m);
    int n = 0;
    for (int i = 0; i < 40; i++) if (m[i]) n++;
    return n;
  endfunction

  function automatic bit is_burst(input logic [39:0] m);
    int lo = -1, hi = -1, n = 0;
    for (int i = 0; i < 40; i++) if (m[i]) begin
      n++;
      if (lo < 0) lo = i;
      hi = i;
    end
    return n > 0 && n <= 3 && (hi - lo + 1) == n;
  endfunction

  function automatic logic [39:0] rand40();
    logic [31:0] lo = $urandom;
    logic [31:0] hi = $urandom;
    return {hi[7:0], lo};
  endfunction

  task automatic do_write(input logic [7:0] a, input logic [31:0] d, input logic [39:0] f);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; wr_flip = f;
    @(negedge clk);
    wr_en = 1'b0; wr_flip = '0;
  endtask

  task automatic do_read(input logic [7:0] a);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    chk(v0 == 1'b1, "R2", "flat valid one edge after", {63'd0, v0}, 64'd1);
    chk(v1 == 1'b0, "R2", "pipe valid early", {63'd0, v1}, 64'd0);
    c_d0 = d0; c_e0 = e0; c_u0 = u0;
    rd_en = 1'b0;
    @(negedge clk);
    chk(v1 == 1'b1, "R2", "pipe valid two edges after", {63'd0, v1}, 64'd1);
    chk(v0 == 1'b0, "R2", "flat valid held", {63'd0, v0}, 64'd0);
    c_d1 = d1; c_e1 = e1; c_u1 = u1;
  endtask

  task automatic judge(input string who, input logic [31:0] d, input logic e, input logic u,
                       input logic [31:0] w, input logic [39:0] f);
    int n = popc(f);
    string rq;
    if (u) ue_seen++;
    if (n == 0) begin
      chk(d == w, "R1", {who, " data"}, {32'd0, d}, {32'd0, w});
      chk({e, u} == 2'b00, "R1", {who, " flags"}, {62'd0, e, u}, 64'd0);
    end else if (is_burst(f)) begin
      rq = (n == 1) ? "R3" : (n == 2) ? "R4" : "R5";
      chk(d == w, rq, {who, " corrected data"}, {32'd0, d}, {32'd0, w});
      chk({e, u} == 2'b10, rq, {who, " flags"}, {62'd0, e, u}, 64'd2);
    end else begin
      if (n == 2 && f[7:0] == 8'd0)
        chk(e && (u || d != w), "R6", {who, " non-adjacent double"},
            {31'd0, e, u, d}, {31'd0, 1'b1, 1'b1, w});
      if (n == 2)
        chk(e == 1'b1, "R6", {who, " double seen"}, {63'd0, e}, 64'd1);
      if (u)
        chk(d == (w ^ f[39:8]), "R7", {who, " raw pass-through"},
            {32'd0, d}, {32'd0, w ^ f[39:8]});
    end
  endtask

  task automatic one_case(input logic [7:0] a, input logic [31:0] w, input logic [39:0] f);
    do_write(a, w, f);
    do_read(a);
    judge("flat", c_d0, c_e0, c_u0, w, f);
    judge("pipe", c_d1, c_e1, c_u1, w, f);
  endtask

  logic [31:0] sh_d [16];
  logic [39:0] sh_f [16];

  initial begin
    void'($urandom(32'h5eed_2024));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk({v0, e0, u0} == 3'b000 && d0 == 32'd0, "R8", "flat reset outputs", {28'd0, v0, e0, u0, d0}, 64'd0);
    chk({v1, e1, u1} == 3'b000 && d1 == 32'd0, "R8", "pipe reset outputs", {28'd0, v1, e1, u1, d1}, 64'd0);

    // R1 clean patterns
    one_case(8'd0, 32'h0000_0000, 40'd0);
    one_case(8'd1, 32'hFFFF_FFFF, 40'd0);
    one_case(8'd255, 32'hA5A5_5A5A, 40'd0);

    // R3 R4 R5 every burst of length one to three
    for (int p = 0; p < 40; p++)
      for (int l = 1; l <= 3; l++)
        if (p + l <= 40) one_case(8'(p), $urandom, ((40'd1 << l) - 40'd1) << p);

    // R9 rewrite clears an earlier corrupted word
    do_write(8'd9, 32'h1234_5678, 40'h00_0100_0101);
    one_case(8'd9, 32'h1234_5678, 40'd0);

    // R6 directed non-adjacent data doubles
    one_case(8'd10, 32'hDEAD_BEEF, (40'd1 << 8) | (40'd1 << 10));
    one_case(8'd11, 32'h0F0F_0F0F, (40'd1 << 20) | (40'd1 << 39));

    // random mix with a shadow of 16 addresses
    for (int it = 0; it < 20; it++) begin
      for (int k = 0; k < 16; k++) begin
        logic [39:0] f;
        int t = int'($urandom % 6);
        int i, j;
        case (t)
          0: f = '0;
          1: f = 40'd1 << ($urandom % 40);
          2: f = 40'd3 << ($urandom % 39);
          3: f = 40'd7 << ($urandom % 38);
          4: begin
            i = 8 + int'($urandom % 32);
            do j = 8 + int'($urandom % 32); while (j - i < 2 && i - j < 2);
            f = (40'd1 << i) | (40'd1 << j);
          end
          default: f = rand40() | (40'd1 << ($urandom % 40));
        endcase
        sh_d[k] = $urandom;
        sh_f[k] = f;
        do_write(8'(16 * (it % 16) + k), sh_d[k], f);
      end
      for (int k = 15; k >= 0; k--) begin
        do_read(8'(16 * (it % 16) + k));
        judge("flat", c_d0, c_e0, c_u0, sh_d[k], sh_f[k]);
        judge("pipe", c_d1, c_e1, c_u1, sh_d[k], sh_f[k]);
      end
    end

    chk(ue_seen > 0, "R7", "uncorrectable reads observed", 64'(ue_seen), 64'd1);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule